// File: doc/BRIEF.md
# Prescaled Seconds Timer with Alarm

A free-running up-counter for wall-clock style timekeeping inside a larger chip. A slow tick input, supplied as a single-cycle enable already synchronous to the bus clock, is divided by a programmable prescaler. Every completed prescaler period advances a 32-bit counter by one. With the prescaler set to the slow tick rate, the counter advances once per second. Software cannot load the counter. It can only restart it from zero. Software keeps any time base in storage elsewhere and adds it to the counter value.

A 32-bit compare value raises a sticky alarm flag when the counter steps onto it. A second sticky flag records every step. Reading the status register clears both flags. The interrupt line is the OR of each flag gated by its own enable. The compare value resets to all-ones, and software uses that value to mean that no alarm is set.

Top module: `sec_timer`

## Requirements
- R1: After reset the counter reads 0, the alarm register reads 0xFFFFFFFF, status reads 0, irq is low, and the mode register reads the prescaler reset value (default 0x8000) with both interrupt enables clear.
- R2: Word registers sit at byte offsets 0x0 (mode), 0x4 (alarm, read/write), 0x8 (counter, read-only) and 0xC (status, read-only). In the mode register, bits 15:0 are the prescaler, bit 16 is the alarm interrupt enable and bit 17 is the step interrupt enable. Status bit 0 is the alarm flag and status bit 1 is the step flag.
- R3: Writing the mode register with bit 18 set clears the counter and the prescaler phase on that clock edge. The new mode fields are written on the same edge. Bit 18 always reads 0. A restart overrides a tick in the same cycle.
- R4: With prescaler value P between 1 and 65535, the counter rises by exactly one on every P-th slow tick counted from a restart, and it holds between those ticks.
- R5: A prescaler value of 0 divides by 65536.
- R6: The alarm flag is set on the edge where a step makes the counter equal to the alarm register. It stays set until it is cleared, and it is set once per pass through the value. A restart to zero is not a step.
- R7: The step flag is set on every counter step and stays set until it is cleared.
- R8: A read of offset 0xC returns the flags and then clears them. If an event occurs in the same cycle as the read, its flag stays set after the read.
- R9: irq is high exactly when (status bit 0 and mode bit 16) or (status bit 1 and mode bit 17).
- R10: Writes to offsets 0x8 and 0xC change nothing. Reads of any offset other than 0x0, 0x4, 0x8 and 0xC return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable per slow clock period |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | ADDR_W (4) | Byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid while bus_rd is high |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit prescaler, a 32-bit counter, a 4-bit byte address and the alarm compare present. Small prescaler values make steps cheap. This lets directed scenarios reach a alarm match and then pass beyond it, a restart that collides with a tick, and a status read that collides with a step. The zero-prescaler case is covered by one long burst of 65536 ticks. Counter wrap at 2^32 is out of reach with these widths.

// File: rtl/sec_timer_pkg.sv
package sec_timer_pkg;
   typedef enum logic [1:0] {
      REG_MODE   = 2'd0,
      REG_ALARM  = 2'd1,
      REG_VALUE  = 2'd2,
      REG_STATUS = 2'd3
   } reg_sel_e;

   localparam int ST_ALM = 0;
   localparam int ST_STEP = 1;
   localparam int ST_W = 2;
endpackage

// File: rtl/sec_timer_prescale.sv
module sec_timer_prescale #(
   parameter int PRESC_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               slow_tick,
   input  logic               restart,
   input  logic [PRESC_W-1:0] presc,
   output logic               wrap
);
   logic [PRESC_W-1:0] phase;
   logic [PRESC_W-1:0] last;

   // value 0 minus one wraps to all-ones, giving a 2^PRESC_W period
   assign last = presc - 1'b1;
   assign wrap = slow_tick && !restart && (phase == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (restart)
         phase <= '0;
      else if (slow_tick)
         phase <= (phase == last) ? '0 : phase + 1'b1;
   end

   p_phase_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (phase == '0));
   p_phase_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase == '0));
endmodule

// File: rtl/sec_timer_counter.sv
module sec_timer_counter #(
   parameter int CNT_W    = 32,
   parameter bit ALARM_ON = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             step,
   input  logic [CNT_W-1:0] alarm,
   output logic [CNT_W-1:0] cnt,
   output logic             alm_evt
);
   logic [CNT_W-1:0] nxt;

   assign nxt = cnt + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart)
         cnt <= '0;
      else if (step)
         cnt <= nxt;
   end

   generate
      if (ALARM_ON) begin : g_alarm
         // evaluated against the value the counter is about to take
         assign alm_evt = step && !restart && (nxt == alarm);
      end else begin : g_no_alarm
         logic unused_alarm;
         assign unused_alarm = ^alarm;
         assign alm_evt = 1'b0;
      end
   endgenerate

   p_restart_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));
   p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !restart) |=> (cnt == $past(cnt) + 1'b1));
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !restart) |=> $stable(cnt));
   p_alarm_eq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      alm_evt |=> (cnt == $past(alarm)));
endmodule

// File: rtl/sec_timer_regs.sv
module sec_timer_regs
   import sec_timer_pkg::*;
#(
   parameter int              ADDR_W    = 4,
   parameter int              DATA_W    = 32,
   parameter int              PRESC_W   = 16,
   parameter int              CNT_W     = 32,
   parameter logic [PRESC_W-1:0] PRESC_RST = 16'h8000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]   cnt,
   input  logic               step,
   input  logic               alm_evt,
   output logic [PRESC_W-1:0] presc,
   output logic [CNT_W-1:0]   alarm,
   output logic               restart,
   output logic               irq
);
   localparam int EN_ALM = PRESC_W + ST_ALM;
   localparam int EN_STEP = PRESC_W + ST_STEP;
   localparam int RST_BIT = PRESC_W + ST_W;

   logic            mapped;
   reg_sel_e        sel;
   logic [ST_W-1:0] en_q;
   logic [ST_W-1:0] st_q;
   logic [ST_W-1:0] evt;
   logic            wr_mode;
   logic            wr_alarm;
   logic            rd_stat;

   assign sel = reg_sel_e'(bus_addr[3:2]);

   generate
      if (ADDR_W > 4) begin : g_wide_addr
         assign mapped = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:4] == '0);
      end else begin : g_exact_addr
         assign mapped = (bus_addr[1:0] == 2'b00);
      end
   endgenerate

   assign wr_mode  = bus_wr && mapped && (sel == REG_MODE);
   assign wr_alarm = bus_wr && mapped && (sel == REG_ALARM);
   assign rd_stat  = bus_rd && mapped && (sel == REG_STATUS);
   assign restart  = wr_mode && bus_wdata[RST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         presc <= PRESC_RST;
         en_q  <= '0;
      end else if (wr_mode) begin
         presc <= bus_wdata[PRESC_W-1:0];
         en_q  <= bus_wdata[EN_STEP:EN_ALM];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         alarm <= '1;
      else if (wr_alarm)
         alarm <= bus_wdata[CNT_W-1:0];
   end

   always_comb begin
      evt = '0;
      evt[ST_ALM] = alm_evt;
      evt[ST_STEP] = step;
   end

   // a fresh event overrides the clear that a status read performs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= '0;
      else
         st_q <= evt | (rd_stat ? '0 : st_q);
   end

   assign irq = |(st_q & en_q);

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && mapped) begin
         case (sel)
            REG_MODE: begin
               bus_rdata[PRESC_W-1:0] = presc;
               bus_rdata[EN_STEP:EN_ALM] = en_q;
            end
            REG_ALARM:  bus_rdata[CNT_W-1:0] = alarm;
            REG_VALUE:  bus_rdata[CNT_W-1:0] = cnt;
            REG_STATUS: bus_rdata[ST_W-1:0] = st_q;
            default:    bus_rdata = '0;
         endcase
      end
   end

   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[ST_ALM] && !rd_stat) |=> st_q[ST_ALM]);
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[ST_STEP] && !rd_stat) |=> st_q[ST_STEP]);
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !step) |=> (st_q == '0));
   p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> st_q[ST_STEP]);
   p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> !irq);
   p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (bus_rdata == '0));
endmodule

// File: rtl/sec_timer.sv
module sec_timer #(
   parameter int              ADDR_W    = 4,
   parameter int              DATA_W    = 32,
   parameter int              PRESC_W   = 16,
   parameter int              CNT_W     = 32,
   parameter logic [PRESC_W-1:0] PRESC_RST = 16'h8000,
   parameter bit              ALARM_ON  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_tick,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   initial begin
      if (ADDR_W < 4) $error("sec_timer: ADDR_W must be at least 4");
      if (DATA_W < PRESC_W + 3) $error("sec_timer: DATA_W too narrow for mode fields");
      if (CNT_W > DATA_W) $error("sec_timer: CNT_W exceeds DATA_W");
      if (PRESC_W < 1) $error("sec_timer: PRESC_W must be positive");
   end

   logic [PRESC_W-1:0] presc;
   logic [CNT_W-1:0]   alarm;
   logic [CNT_W-1:0]   cnt;
   logic               restart;
   logic               step;
   logic               alm_evt;

   sec_timer_prescale #(.PRESC_W(PRESC_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
      .restart(restart), .presc(presc), .wrap(step)
   );

   sec_timer_counter #(.CNT_W(CNT_W), .ALARM_ON(ALARM_ON)) u_cnt (
      .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
      .alarm(alarm), .cnt(cnt), .alm_evt(alm_evt)
   );

   sec_timer_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRESC_W(PRESC_W),
      .CNT_W(CNT_W), .PRESC_RST(PRESC_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt(cnt), .step(step), .alm_evt(alm_evt), .presc(presc),
      .alarm(alarm), .restart(restart), .irq(irq)
   );
endmodule

// File: tb/sec_timer_test.sv
module sec_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   localparam logic [31:0] RST18 = 32'h0004_0000;
   localparam logic [31:0] AEN = 32'h0001_0000;
   localparam logic [31:0] SEN = 32'h0002_0000;

   always #2 clk = ~clk;

   sec_timer uut (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      slow_tick = 1'b1;
      repeat (n) @(negedge clk);
      slow_tick = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(4'h8, d); check("R1 counter", d, 0);
      rd(4'h4, d); check("R1 alarm", d, 32'hFFFF_FFFF);
      rd(4'hC, d); check("R1 status", d, 0);
      rd(4'h0, d); check("R1 mode", d, 32'h0000_8000);
      check("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_regmap;
      logic [31:0] d;
      wr(4'h0, 32'h0003_1234 | RST18);
      rd(4'h0, d); check("R2 mode fields, R3 restart bit reads 0", d, 32'h0003_1234);
      wr(4'h4, 32'hA5A5_0F0F);
      rd(4'h4, d); check("R2 alarm rw", d, 32'hA5A5_0F0F);
      wr(4'h0, 32'h0000_0003 | RST18);
      wr(4'h4, 32'hFFFF_FFFF);
      rd(4'hC, d);
   endtask

   task automatic t_count;
      logic [31:0] d;
      wr(4'h0, 32'd3 | RST18);
      ticks(2); rd(4'h8, d); check("R4 holds before period", d, 0);
      ticks(1); rd(4'h8, d); check("R4 first step", d, 1);
      ticks(7); rd(4'h8, d); check("R4 after 10 ticks", d, 3);
      ticks(2); rd(4'h8, d); check("R4 after 12 ticks", d, 4);
      rd(4'hC, d);
   endtask

   task automatic t_restart;
      logic [31:0] d;
      ticks(2);
      wr(4'h0, 32'd3 | RST18);
      rd(4'h8, d); check("R3 counter zero", d, 0);
      ticks(2); rd(4'h8, d); check("R3 phase restarted", d, 0);
      ticks(1); rd(4'h8, d); check("R3 step after fresh period", d, 1);
      ticks(2);
      @(negedge clk);
      slow_tick = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'd3 | RST18;
      @(negedge clk);
      slow_tick = 1'b0; bus_wr = 1'b0;
      rd(4'h8, d); check("R3 restart beats tick", d, 0);
      rd(4'hC, d);
   endtask

   task automatic t_alarm;
      logic [31:0] d;
      wr(4'h0, 32'd2 | AEN | RST18);
      wr(4'h4, 32'd3);
      rd(4'hC, d);
      ticks(5);
      check("R9 irq low before alarm", {31'b0, irq}, 0);
      ticks(1);
      check("R6 R9 irq on alarm", {31'b0, irq}, 1);
      rd(4'hC, d); check("R6 R7 status after match", d, 32'h3);
      check("R8 irq drops after read", {31'b0, irq}, 0);
      rd(4'hC, d); check("R8 status cleared", d, 0);
      ticks(4);
      rd(4'hC, d); check("R6 once per pass", d & 32'h1, 0);
      wr(4'h0, 32'd2 | AEN | RST18);
      rd(4'hC, d); check("R6 restart is not a step", d, 0);
      wr(4'h4, 32'hFFFF_FFFF);
   endtask

   task automatic t_step_flag;
      logic [31:0] d;
      wr(4'h0, 32'd1 | SEN | RST18);
      rd(4'hC, d);
      check("R9 irq low without step", {31'b0, irq}, 0);
      ticks(1);
      check("R7 R9 step irq", {31'b0, irq}, 1);
      @(negedge clk);
      check("R7 step flag sticky", {31'b0, irq}, 1);
      rd(4'hC, d); check("R7 step flag", d, 32'h2);
      // read collides with a step
      @(negedge clk);
      slow_tick = 1'b1; bus_rd = 1'b1; bus_addr = 4'hC;
      #1 d = bus_rdata;
      @(negedge clk);
      slow_tick = 1'b0; bus_rd = 1'b0;
      check("R8 collision read sees old", d, 0);
      rd(4'hC, d); check("R8 event wins over clear", d, 32'h2);
      wr(4'h0, 32'd1);
      ticks(1);
      check("R9 masked step no irq", {31'b0, irq}, 0);
      rd(4'hC, d);
   endtask

   task automatic t_ignored;
      logic [31:0] d;
      wr(4'h0, 32'd3 | RST18);
      ticks(3);
      wr(4'h8, 32'h1234_5678);
      rd(4'h8, d); check("R10 counter write ignored", d, 1);
      wr(4'hC, 32'h0);
      rd(4'hC, d); check("R10 status write ignored", d, 32'h2);
      rd(4'h2, d); check("R10 unaligned reads 0", d, 0);
      rd(4'h5, d); check("R10 offset 5 reads 0", d, 0);
   endtask

   task automatic t_presc_zero;
      logic [31:0] d;
      wr(4'h0, 32'd0 | RST18);
      ticks(65535);
      rd(4'h8, d); check("R5 no step at 65535", d, 0);
      ticks(1);
      rd(4'h8, d); check("R5 step at 65536", d, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_regmap;
      t_count;
      t_restart;
      t_alarm;
      t_step_flag;
      t_ignored;
      t_presc_zero;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #790000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule